// File: doc/BRIEF.md
# Least-Slack Lookup Memory Arbiter

Four functional units share one lookup memory through this arbiter. Each unit raises a request with a key, an absolute deadline and an expected computation time. In every cycle the arbiter works out how much slack each pending request has left: the deadline, minus the computation time, minus the current value of a free-running timestamp counter. It then issues to the memory the request with the smallest slack. The key goes out tagged with the index of the unit that asked for it.

The memory answers later with the data and the same tag. The arbiter uses the tag to steer the answer back to that unit. A unit keeps its request raised until it sees its grant pulse, and it may have only one lookup in flight at a time. A request whose slack has already gone negative is still issued, and a lateness pulse for that unit goes out alongside its grant.

Top module: `llf_mem_arbiter`

## Requirements
- R1: While reset is asserted, and directly after it is released (before the first clock edge), `cur_time`, `req_grant`, `req_late`, `mem_req` and `rsp_valid` are all zero.
- R2: The timestamp `cur_time` increases by one on every clock edge and wraps modulo 2^TIME_W.
- R3: The slack of requester i is (deadline_i − ctime_i − cur_time) mod 2^TIME_W, read as a two's-complement signed value. All three terms are taken in the cycle before the grant edge.
- R4: Eligible requesters are those with `req_valid` high and no lookup in flight. On the next clock edge, the eligible requester with the smallest slack is granted: its `req_grant` bit pulses for one cycle and `mem_req` is high for that same cycle.
- R5: When two or more eligible requesters share the smallest slack, the one with the lowest index wins.
- R6: In the grant cycle, `mem_key` carries the winner's key and `mem_id` carries the winner's index as an unsigned binary number.
- R7: At most one `req_grant` bit is high in any cycle. If no requester is eligible, `req_grant` is zero and `mem_req` is low.
- R8: Once a requester is granted, it is not granted again until a memory response whose `mem_rid` equals its index has been accepted. This holds even if its `req_valid` stays high.
- R9: A response presented with `mem_rvalid` high appears one clock edge later. At that point `rsp_valid` is one-hot at bit `mem_rid`, and `rsp_data` equals `mem_rdata`.
- R10: `req_late[i]` pulses together with `req_grant[i]` exactly when the granted slack is negative, that is, when its sign bit (bit TIME_W−1) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request raised, one bit per unit |
| req_key | input | NREQ×KEY_W | Lookup key per unit |
| req_deadline | input | NREQ×TIME_W | Absolute deadline per unit |
| req_ctime | input | NREQ×TIME_W | Computation time per unit |
| req_grant | output | NREQ | One-cycle grant pulse per unit |
| req_late | output | NREQ | Negative-slack flag, pulses with the grant |
| cur_time | output | TIME_W | Free-running timestamp |
| mem_req | output | 1 | Lookup issued to memory |
| mem_key | output | KEY_W | Issued key |
| mem_id | output | ID_W | Index of the issuing unit |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rid | input | ID_W | Index carried by the response |
| mem_rdata | input | DATA_W | Response data |
| rsp_valid | output | NREQ | Response delivered, one bit per unit |
| rsp_data | output | DATA_W | Delivered response data |

## Verification
The bench builds the block with its defaults: NREQ=4, KEY_W=12, DATA_W=16 and TIME_W=16. The memory model in the bench uses a latency of three cycles. With four requesters, the bench can sweep all sixteen request masks against six slack patterns. These patterns cover full ties, pairwise ties, strictly ordered slacks, negative slacks, and computation times large enough that deadline minus computation time wraps. That sweep reaches every tie-break path and every lateness case. A separate sequence holds a single request high to show that an in-flight lookup blocks a second grant until its response returns.

// File: rtl/llf_mem_arbiter.sv
module llf_mem_arbiter #(
  parameter int NREQ   = 4,
  parameter int KEY_W  = 12,
  parameter int DATA_W = 16,
  parameter int TIME_W = 16,
  localparam int ID_W  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NREQ-1:0]               req_valid,
  input  logic [NREQ-1:0][KEY_W-1:0]    req_key,
  input  logic [NREQ-1:0][TIME_W-1:0]   req_deadline,
  input  logic [NREQ-1:0][TIME_W-1:0]   req_ctime,
  output logic [NREQ-1:0]               req_grant,
  output logic [NREQ-1:0]               req_late,
  output logic [TIME_W-1:0]             cur_time,
  output logic                          mem_req,
  output logic [KEY_W-1:0]              mem_key,
  output logic [ID_W-1:0]               mem_id,
  input  logic                          mem_rvalid,
  input  logic [ID_W-1:0]               mem_rid,
  input  logic [DATA_W-1:0]             mem_rdata,
  output logic [NREQ-1:0]               rsp_valid,
  output logic [DATA_W-1:0]             rsp_data
);

  logic [TIME_W-1:0]        now_q;
  logic [NREQ-1:0]          busy_q;
  logic [NREQ-1:0]          eligible;
  logic [NREQ-1:0][TIME_W-1:0] slack;

  logic                     win_found;
  logic [ID_W-1:0]          win_idx;
  logic signed [TIME_W-1:0] win_slack;

  assign cur_time = now_q;
  assign eligible = req_valid & ~busy_q;

  for (genvar g = 0; g < NREQ; g++) begin : g_slack
    assign slack[g] = req_deadline[g] - req_ctime[g] - now_q;
  end

  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    win_slack = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (eligible[i] && (!win_found || $signed(slack[i]) < win_slack)) begin
        win_found = 1'b1;
        win_idx   = ID_W'(i);
        win_slack = $signed(slack[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q     <= '0;
      req_grant <= '0;
      req_late  <= '0;
      mem_req   <= 1'b0;
      mem_key   <= '0;
      mem_id    <= '0;
    end else begin
      now_q     <= now_q + 1'b1;
      req_grant <= '0;
      req_late  <= '0;
      mem_req   <= win_found;
      if (win_found) begin
        req_grant[win_idx] <= 1'b1;
        req_late[win_idx]  <= win_slack[TIME_W-1];
        mem_key            <= req_key[win_idx];
        mem_id             <= win_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else begin
      for (int i = 0; i < NREQ; i++) begin
        if (win_found && win_idx == ID_W'(i))
          busy_q[i] <= 1'b1;
        else if (mem_rvalid && mem_rid == ID_W'(i))
          busy_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= '0;
      if (mem_rvalid) begin
        rsp_valid[mem_rid] <= 1'b1;
        rsp_data           <= mem_rdata;
      end
    end
  end

  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_grant));

  a_r7_req_matches_grant: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req == (req_grant != '0));

  a_r6_id_of_grant: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> req_grant[mem_id]);

  a_r9_rsp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  for (genvar g = 0; g < NREQ; g++) begin : g_chk
    a_r4_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant[g] |-> $past(req_valid[g]));

    a_r8_no_second_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant[g] |-> !$past(busy_q[g]));

    a_r10_late_only_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
      req_late[g] |-> req_grant[g]);

    a_r9_route_by_id: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[g] |-> ($past(mem_rvalid) && $past(mem_rid) == ID_W'(g)));
  end

endmodule

// File: tb/test_llf_mem_arbiter.sv
module test_llf_mem_arbiter;
  localparam int NREQ = 4, KEY_W = 12, DATA_W = 16, TIME_W = 16, ID_W = 2;
  localparam int MEM_LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREQ-1:0]               req_valid = '0;
  logic [NREQ-1:0][KEY_W-1:0]    req_key = '0;
  logic [NREQ-1:0][TIME_W-1:0]   req_deadline = '0;
  logic [NREQ-1:0][TIME_W-1:0]   req_ctime = '0;
  logic [NREQ-1:0]               req_grant, req_late, rsp_valid;
  logic [TIME_W-1:0]             cur_time;
  logic                          mem_req;
  logic [KEY_W-1:0]              mem_key;
  logic [ID_W-1:0]               mem_id;
  logic                          mem_rvalid = 1'b0;
  logic [ID_W-1:0]               mem_rid = '0;
  logic [DATA_W-1:0]             mem_rdata = '0;
  logic [DATA_W-1:0]             rsp_data;

  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  llf_mem_arbiter #(.NREQ(NREQ), .KEY_W(KEY_W), .DATA_W(DATA_W), .TIME_W(TIME_W)) i_llf_mem_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_key(req_key),
    .req_deadline(req_deadline), .req_ctime(req_ctime), .req_grant(req_grant),
    .req_late(req_late), .cur_time(cur_time), .mem_req(mem_req), .mem_key(mem_key),
    .mem_id(mem_id), .mem_rvalid(mem_rvalid), .mem_rid(mem_rid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] resp_of(input logic [KEY_W-1:0] k);
    return {4'hC, k} ^ 16'h5A5A;
  endfunction

  task automatic respond(input int id, input logic [KEY_W-1:0] k);
    repeat (MEM_LAT - 1) begin
      @(negedge clk);
      check(req_grant == '0, "R7 idle", req_grant, 0);
    end
    mem_rvalid = 1'b1;
    mem_rid    = ID_W'(id);
    mem_rdata  = resp_of(k);
    @(negedge clk);
    mem_rvalid = 1'b0;
    check(rsp_valid == (NREQ'(1) << id), "R9 rsp_valid", rsp_valid, NREQ'(1) << id);
    check(rsp_data == resp_of(k), "R9 rsp_data", rsp_data, resp_of(k));
  endtask

  task automatic run_case(input int mask, input int p);
    logic [TIME_W-1:0] t;
    logic signed [TIME_W-1:0] s [NREQ];
    int win;
    logic signed [TIME_W-1:0] best;
    @(negedge clk);
    t = cur_time;
    for (int i = 0; i < NREQ; i++) begin
      logic [TIME_W-1:0] ct, rel;
      case (p)
        0: begin ct = 16'd10;          rel = 16'd100; end
        1: begin ct = 16'd5;           rel = TIME_W'(40 - i * 7); end
        2: begin ct = TIME_W'(i * 9);  rel = TIME_W'(20 + i * 3); end
        3: begin ct = TIME_W'(2 + i * 2); rel = 16'd3; end
        4: begin ct = 16'hFFF0;        rel = TIME_W'(16'hFFF0 + 50 - i * 20); end
        default: begin ct = TIME_W'(i * 100); rel = TIME_W'(8 - (i >> 1) * 8 + i * 100); end
      endcase
      req_ctime[i]    = ct;
      req_deadline[i] = t + rel;
      req_key[i]      = KEY_W'(i * 12'h300 + mask * 16 + p);
      s[i]            = $signed(rel - ct);
    end
    req_valid = NREQ'(mask);
    win = -1;
    best = '0;
    for (int i = 0; i < NREQ; i++)
      if (mask[i] && (win < 0 || s[i] < best)) begin
        win = i;
        best = s[i];
      end
    @(negedge clk);
    req_valid = '0;
    if (win < 0) begin
      check(req_grant == '0 && !mem_req, "R7 no grant when idle", req_grant, 0);
    end else begin
      check(req_grant == (NREQ'(1) << win), "R4/R5 least-slack winner", req_grant, NREQ'(1) << win);
      check(mem_req, "R4 mem_req", mem_req, 1);
      check(mem_id == ID_W'(win), "R6 mem_id", mem_id, win);
      check(mem_key == req_key[win], "R6 mem_key", mem_key, req_key[win]);
      check(req_late == (best < 0 ? (NREQ'(1) << win) : '0), "R3/R10 late flag",
            req_late, best < 0 ? (NREQ'(1) << win) : 0);
      respond(win, req_key[win]);
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [TIME_W-1:0] t0;
    repeat (3) @(negedge clk);
    check(req_grant == '0 && req_late == '0 && !mem_req && rsp_valid == '0, "R1 reset outputs", req_grant, 0);
    rst_n = 1'b1;
    check(cur_time == '0, "R1 time zero", cur_time, 0);
    check(!mem_req && rsp_valid == '0, "R1 idle after release", mem_req, 0);

    @(negedge clk);
    t0 = cur_time;
    @(negedge clk);
    check(cur_time == t0 + 1'b1, "R2 time step", cur_time, t0 + 1'b1);

    for (int p = 0; p < 6; p++)
      for (int m = 0; m < 16; m++)
        run_case(m, p);

    // R8: held request is not re-granted while its lookup is in flight
    @(negedge clk);
    req_key[2] = 12'hABC;
    req_deadline[2] = cur_time + 16'd500;
    req_ctime[2] = 16'd1;
    req_valid = 4'b0100;
    @(negedge clk);
    check(req_grant == 4'b0100, "R8 first grant", req_grant, 4'b0100);
    repeat (4) begin
      @(negedge clk);
      check(req_grant == '0, "R8 blocked while in flight", req_grant, 0);
    end
    mem_rvalid = 1'b1; mem_rid = 2'd2; mem_rdata = resp_of(12'hABC);
    @(negedge clk);
    mem_rvalid = 1'b0;
    check(rsp_valid == 4'b0100, "R9 held response", rsp_valid, 4'b0100);
    @(negedge clk);
    check(req_grant == 4'b0100, "R8 regrant after response", req_grant, 4'b0100);
    req_valid = '0;
    respond(2, 12'hABC);

    @(negedge clk);
    t0 = cur_time;
    repeat (5) @(negedge clk);
    check(cur_time == t0 + 16'd5, "R2 time run", cur_time, t0 + 16'd5);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule